// File: doc/BRIEF.md
# Cascaded Column-Driver Write Master

This block is the host side of a serial link to a row of cascaded display column drivers. Each driver holds a fixed number of 8-bit columns (24 by default), and up to four of them share one serial clock and one data line while each has its own active-low select. A command gives a global start column, a column count and a direction. The block works out which driver owns the start column and the local column address inside that driver. It then sends the run as a series of 30-bit frames, three columns per frame, and moves on to the next driver whenever the local address reaches the end of a driver.

In a write, the block pulls one byte per column from a byte source through a one-cycle take strobe. In a read, it collects three bytes per frame from the shared return line and hands each one out with a one-cycle valid strobe, which is what a scroll routine needs. The first accepted command after reset is preceded by one full-length frame with no driver selected, so that every driver's serial receiver starts in a known place.

The controller is a five-state machine. IDLE waits for an accepted command (IDLE→LOAD). LOAD starts a frame and clears the bit index (LOAD→CLK_LO). CLK_LO holds the serial clock low for one half period (CLK_LO→CLK_HI). CLK_HI holds it high for one half period and then moves to the next bit (CLK_HI→CLK_LO), or leaves after the last bit (CLK_HI→GAP). GAP keeps every select high for one half period. From GAP the block starts the first real frame after the priming frame, or the next chunk (GAP→LOAD), or returns to IDLE after the last chunk (GAP→IDLE).

Top module: `lcdw_chunk_writer`

## Requirements
- R1: While reset is held and while the block is idle, all four selects are high (4'b1111), the serial clock is low, busy is low, and the take and read-valid strobes are low.
- R2: A command is ignored, and busy stays low, when its start column or column count is not a multiple of 3, when its count is zero, or when its start column is 96 or more.
- R3: The first accepted command after reset is preceded by one frame of 30 clock pulses with all selects high, data low and no byte taken. Later commands send no such frame.
- R4: A frame is 30 rising clock edges under one unchanging select. The line carries the 5-bit local address MSB first, then a direction bit (1 = read, 0 = write), then 24 data bits: three bytes in column order, each sent LSB first. The data line changes only while the clock is low.
- R5: The driver is chosen by taking 24 from the start column until the rest is below 24. Driver k is selected by driving select bit k low, so driver 0 gets 4'b1110, driver 1 4'b1101, driver 2 4'b1011 and driver 3 4'b0111. At most one select is ever low.
- R6: Each frame covers 3 columns, and the next frame's address is 3 higher. When the address would reach 24, it becomes 0 and the select moves to the next driver, with driver 3 followed by driver 0.
- R7: Each clock low phase and each high phase lasts HALF_CYC system cycles (2 by default). Between frames, all selects stay high with the clock low for at least HALF_CYC cycles.
- R8: A write frame pulses the take strobe for exactly one cycle per byte, three times per frame. The byte present in the pulse cycle is the one sent for that column.
- R9: In a read frame, the return line is sampled in the last cycle of each data bit's low phase. Bits are gathered LSB first, and each completed byte is shown on the read-byte output with a one-cycle valid pulse, three per frame.
- R10: Busy rises in the cycle after an accepted command and falls only after the last frame has ended with all selects high. A command given while busy is ignored.
- R11: A read frame takes no bytes and sends zeros in its data bits. A write frame raises no read-valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_go | input | 1 | One-cycle command strobe |
| cmd_read | input | 1 | Direction of the command: 1 read, 0 write |
| cmd_col | input | 7 | Global start column |
| cmd_len | input | 7 | Number of columns |
| wbyte | input | 8 | Next byte of the write stream |
| wbyte_take | output | 1 | Consumes wbyte in this cycle |
| rbyte | output | 8 | Byte gathered from the return line |
| rbyte_vld | output | 1 | rbyte is new in this cycle |
| busy | output | 1 | A command is in progress |
| drv_clk | output | 1 | Serial clock to the drivers |
| drv_dout | output | 1 | Serial data to the drivers |
| drv_din | input | 1 | Serial return data from the drivers |
| drv_sel_n | output | 4 | One-hot active-low driver selects |

## Verification
A wrong local address or a select that failed to rotate is visible in the very next frame. Its first five clock pulses carry the address, and the select pattern sits under all 30 pulses, so an error at a driver boundary shows up within about 130 cycles of the frame in which it arose. A bit index that is off by one moves every later field of the frame: the direction bit lands in the wrong place and the data bytes appear rotated, so one frame is enough to expose it. A priming flag or chunk counter in the wrong state changes the number of frames and takes, and that count is complete when busy falls.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_GAP
    } lcdw_state_e;
endpackage

// File: rtl/lcdw_half_timer.sv
module lcdw_half_timer #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == CW'(HALF_CYC - 1));
endmodule

// File: rtl/lcdw_col_map.sv
module lcdw_col_map #(
    parameter int N_CHIPS = 4,
    parameter int COLS    = 24,
    parameter int COL_W   = 7,
    parameter int ADDR_W  = 5
) (
    input  logic [COL_W-1:0]   col,
    output logic               ok,
    output logic [ADDR_W-1:0]  addr,
    output logic [N_CHIPS-1:0] sel_n
);
    localparam int IDX_W = $clog2(N_CHIPS + 1);

    logic [COL_W-1:0] rem_w [0:N_CHIPS];
    logic [IDX_W-1:0] idx_w [0:N_CHIPS];

    assign rem_w[0] = col;
    assign idx_w[0] = '0;

    for (genvar g = 0; g < N_CHIPS; g++) begin : g_sub
        assign rem_w[g+1] = (rem_w[g] >= COL_W'(COLS)) ? rem_w[g] - COL_W'(COLS) : rem_w[g];
        assign idx_w[g+1] = (rem_w[g] >= COL_W'(COLS)) ? idx_w[g] + 1'b1 : idx_w[g];
    end

    assign ok    = (col < COL_W'(N_CHIPS * COLS));
    assign addr  = rem_w[N_CHIPS][ADDR_W-1:0];
    assign sel_n = ~({{(N_CHIPS-1){1'b0}}, 1'b1} << idx_w[N_CHIPS]);

    // R5: a legal start column always leaves a remainder inside one driver
    always_comb begin
        if (ok) a_r5_local_range: assert (rem_w[N_CHIPS] < COL_W'(COLS));
    end
endmodule

// File: rtl/lcdw_byte_shift.sv
module lcdw_byte_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              shift,
    input  logic              shift_in,
    output logic [BYTE_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {shift_in, q[BYTE_W-1:1]};
    end
endmodule

// File: rtl/lcdw_chunk_writer.sv
module lcdw_chunk_writer
    import lcdw_pkg::*;
#(
    parameter int N_CHIPS       = 4,
    parameter int COLS_PER_CHIP = 24,
    parameter int CHUNK         = 3,
    parameter int BYTE_W        = 8,
    parameter int ADDR_W        = 5,
    parameter int COL_W         = 7,
    parameter int HALF_CYC      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_go,
    input  logic               cmd_read,
    input  logic [COL_W-1:0]   cmd_col,
    input  logic [COL_W-1:0]   cmd_len,
    input  logic [BYTE_W-1:0]  wbyte,
    output logic               wbyte_take,
    output logic [BYTE_W-1:0]  rbyte,
    output logic               rbyte_vld,
    output logic               busy,
    output logic               drv_clk,
    output logic               drv_dout,
    input  logic               drv_din,
    output logic [N_CHIPS-1:0] drv_sel_n
);
    localparam int DATA_START = ADDR_W + 1;
    localparam int FRAME_BITS = DATA_START + CHUNK * BYTE_W;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    lcdw_state_e state_q, state_d;

    logic [BIT_W-1:0]   bit_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [N_CHIPS-1:0] sel_q;
    logic [COL_W-1:0]   left_q;
    logic               rd_q, dummy_q, primed_q, vld_q;

    logic               map_ok;
    logic [ADDR_W-1:0]  map_addr;
    logic [N_CHIPS-1:0] map_sel;
    logic               cmd_ok, accept;
    logic               half_done, tm_clr;
    logic [BYTE_W-1:0]  sh_q;
    logic               sh_shift;
    logic               in_data, at_byte_edge, byte_last, last_bit, last_chunk;
    logic [ADDR_W-1:0]  next_addr, addr_shl;
    logic [BIT_W-1:0]   data_pos;

    lcdw_col_map #(
        .N_CHIPS(N_CHIPS), .COLS(COLS_PER_CHIP), .COL_W(COL_W), .ADDR_W(ADDR_W)
    ) u_map (
        .col(cmd_col), .ok(map_ok), .addr(map_addr), .sel_n(map_sel)
    );

    lcdw_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tm_clr), .done(half_done)
    );

    lcdw_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(wbyte_take), .load_val(wbyte),
        .shift(sh_shift), .shift_in(drv_din), .q(sh_q)
    );

    assign cmd_ok = map_ok && (cmd_len != '0)
                 && ((cmd_col % COL_W'(CHUNK)) == '0)
                 && ((cmd_len % COL_W'(CHUNK)) == '0);
    assign accept = (state_q == ST_IDLE) && cmd_go && cmd_ok;

    assign tm_clr       = (state_q == ST_IDLE) || (state_q == ST_LOAD) || half_done;
    assign in_data      = (bit_q >= BIT_W'(DATA_START));
    assign data_pos     = bit_q - BIT_W'(DATA_START);
    assign at_byte_edge = (bit_q >= BIT_W'(DATA_START - 1)) && (bit_q < BIT_W'(FRAME_BITS - 1))
                       && (((bit_q - BIT_W'(DATA_START - 1)) % BIT_W'(BYTE_W)) == '0);
    assign byte_last    = in_data && ((data_pos % BIT_W'(BYTE_W)) == BIT_W'(BYTE_W - 1));
    assign last_bit     = (bit_q == BIT_W'(FRAME_BITS - 1));
    assign last_chunk   = (left_q == COL_W'(CHUNK));
    assign next_addr    = addr_q + ADDR_W'(CHUNK);
    assign addr_shl     = addr_q << bit_q;

    assign sh_shift = half_done && in_data && !dummy_q
                   && (((state_q == ST_CLK_HI) && !rd_q) || ((state_q == ST_CLK_LO) && rd_q));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_CLK_LO;
            ST_CLK_LO: if (half_done) state_d = ST_CLK_HI;
            ST_CLK_HI: if (half_done) state_d = last_bit ? ST_GAP : ST_CLK_LO;
            ST_GAP: begin
                if (half_done) begin
                    if (dummy_q || !last_chunk) state_d = ST_LOAD;
                    else                        state_d = ST_IDLE;
                end
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q    <= '0;
            addr_q   <= '0;
            sel_q    <= '1;
            left_q   <= '0;
            rd_q     <= 1'b0;
            dummy_q  <= 1'b0;
            primed_q <= 1'b0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= (state_q == ST_CLK_LO) && half_done && rd_q && !dummy_q && byte_last;
            if (accept) begin
                rd_q    <= cmd_read;
                sel_q   <= map_sel;
                addr_q  <= map_addr;
                left_q  <= cmd_len;
                dummy_q <= !primed_q;
            end
            if (state_q == ST_LOAD) bit_q <= '0;
            if ((state_q == ST_CLK_HI) && half_done && !last_bit) bit_q <= bit_q + 1'b1;
            if ((state_q == ST_GAP) && half_done) begin
                if (dummy_q) begin
                    dummy_q  <= 1'b0;
                    primed_q <= 1'b1;
                end else begin
                    left_q <= left_q - COL_W'(CHUNK);
                    if (next_addr == ADDR_W'(COLS_PER_CHIP)) begin
                        addr_q <= '0;
                        sel_q  <= {sel_q[N_CHIPS-2:0], sel_q[N_CHIPS-1]};
                    end else begin
                        addr_q <= next_addr;
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        logic active;
        active     = (state_q == ST_CLK_LO) || (state_q == ST_CLK_HI);
        busy       = (state_q != ST_IDLE);
        drv_clk    = (state_q == ST_CLK_HI);
        drv_sel_n  = (active && !dummy_q) ? sel_q : '1;
        wbyte_take = (state_q == ST_CLK_HI) && half_done && !rd_q && !dummy_q && at_byte_edge;
        rbyte      = sh_q;
        rbyte_vld  = vld_q;
        drv_dout   = 1'b0;
        if (active && !dummy_q) begin
            if (bit_q < BIT_W'(ADDR_W))       drv_dout = addr_shl[ADDR_W-1];
            else if (bit_q == BIT_W'(ADDR_W)) drv_dout = rd_q;
            else                              drv_dout = !rd_q && sh_q[0];
        end
    end

    // R5: never more than one driver selected
    a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~drv_sel_n) <= 1);
    // R4: data line holds while the clock is high
    a_r4_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_clk && $past(drv_clk)) |-> (drv_dout == $past(drv_dout)));
    // R1: idle means quiet link
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (drv_sel_n == '1 && !drv_clk && !wbyte_take));
    // R8: bytes are only taken under a real select
    a_r8_take_selected: assert property (@(posedge clk) disable iff (!rst_n)
        wbyte_take |-> (drv_sel_n != '1 && drv_clk));
    // R9: read-valid is a single-cycle pulse
    a_r9_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rbyte_vld |=> !rbyte_vld);
    // R10: busy ends only with all selects released
    a_r10_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(drv_sel_n) == '1));
    // R2: rejected commands leave the block idle
    a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_go && !cmd_ok) |=> !busy);
    // R6: local address stays chunk-aligned inside one driver
    a_r6_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (addr_q < ADDR_W'(COLS_PER_CHIP) && (addr_q % ADDR_W'(CHUNK)) == '0));
endmodule

// File: tb/lcdw_chunk_writer_tb.sv
module lcdw_chunk_writer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_go = 1'b0, cmd_read = 1'b0;
    logic [6:0] cmd_col = '0, cmd_len = '0;
    logic [7:0] wbyte;
    logic       wbyte_take;
    logic [7:0] rbyte;
    logic       rbyte_vld, busy, drv_clk, drv_dout;
    logic       drv_din = 1'b0;
    logic [3:0] drv_sel_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdw_chunk_writer #(.HALF_CYC(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_read(cmd_read),
        .cmd_col(cmd_col), .cmd_len(cmd_len), .wbyte(wbyte), .wbyte_take(wbyte_take),
        .rbyte(rbyte), .rbyte_vld(rbyte_vld), .busy(busy), .drv_clk(drv_clk),
        .drv_dout(drv_dout), .drv_din(drv_din), .drv_sel_n(drv_sel_n)
    );

    int n_chk = 0, n_fail = 0;

    function automatic logic [7:0] src_byte(input int i);
        return 8'(i * 37 + 91);
    endfunction

    // byte source
    int src_idx = 0;
    assign wbyte = src_byte(src_idx);
    always @(posedge clk) if (wbyte_take) src_idx <= src_idx + 1;

    // link monitor and driver return model
    logic [29:0] fr_bits [0:31];
    logic [3:0]  fr_cs   [0:31];
    logic        fr_mix  [0:31];
    int          fr_cnt = 0, bcnt = 0;
    logic [29:0] cur_bits = '0;
    logic [3:0]  cur_cs = 4'hF;
    logic        cur_mix = 1'b0, prev_clk = 1'b0, prev_dout = 1'b0;
    int          hi_run = 0, hi_min = 999, hi_max = 0, gap_run = 0, gap_min = 999, glitch = 0;
    logic [23:0] rd_pat = '0;
    logic [7:0]  rd_got [0:15];
    int          rd_cnt = 0;

    always @(negedge clk) begin
        prev_clk  <= drv_clk;
        prev_dout <= drv_dout;
        if (rbyte_vld) begin
            rd_got[rd_cnt] <= rbyte;
            rd_cnt <= rd_cnt + 1;
        end
        if (drv_clk) begin
            hi_run  <= hi_run + 1;
            gap_run <= 0;
        end else if (busy && drv_sel_n == 4'hF) begin
            gap_run <= gap_run + 1;
        end
        if (!drv_clk && prev_clk) begin
            if (hi_run < hi_min) hi_min <= hi_run;
            if (hi_run > hi_max) hi_max <= hi_run;
            hi_run <= 0;
            if (bcnt >= 6 && bcnt < 30) drv_din <= rd_pat[bcnt-6];
        end
        if (drv_sel_n != 4'hF && gap_run > 0) begin
            if (gap_run < gap_min) gap_min <= gap_run;
            gap_run <= 0;
        end
        if (drv_clk && prev_clk && drv_dout != prev_dout) glitch <= glitch + 1;
        if (drv_clk && !prev_clk) begin
            logic [29:0] nb;
            logic        nm;
            nb = cur_bits;
            nb[bcnt] = drv_dout;
            nm = (bcnt == 0) ? 1'b0 : (cur_mix || (drv_sel_n != cur_cs));
            if (bcnt == 29) begin
                fr_bits[fr_cnt] <= nb;
                fr_cs[fr_cnt]   <= drv_sel_n;
                fr_mix[fr_cnt]  <= nm;
                fr_cnt <= fr_cnt + 1;
                bcnt   <= 0;
            end else begin
                bcnt <= bcnt + 1;
            end
            cur_bits <= nb;
            cur_cs   <= drv_sel_n;
            cur_mix  <= nm;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input int col, input int len, input bit rd);
        @(negedge clk);
        cmd_go = 1'b1; cmd_read = rd; cmd_col = 7'(col); cmd_len = 7'(len);
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_frame(input int fi, input logic [3:0] cs, input int addr, input bit rw,
                                input logic [23:0] data, input string req);
        logic [29:0] b;
        logic [4:0]  a;
        logic [23:0] d;
        b = fr_bits[fi];
        a = {b[0], b[1], b[2], b[3], b[4]};
        d = b[29:6];
        chk(fr_cs[fi] == cs && !fr_mix[fi], req, "frame select", fr_cs[fi], cs);
        chk(a == 5'(addr) && b[5] == rw, req, "address and direction", {a, b[5]}, {5'(addr), rw});
        chk(d == data, req, "frame data", d, data);
    endtask

    function automatic logic [23:0] wr_data(input int base);
        return {src_byte(base + 2), src_byte(base + 1), src_byte(base)};
    endfunction

    task automatic t_reset();
        chk(drv_sel_n == 4'hF && !drv_clk && !busy && !wbyte_take && !rbyte_vld, "R1",
            "idle outputs", {drv_sel_n, drv_clk, busy, wbyte_take, rbyte_vld}, 8'hF0);
    endtask

    task automatic t_reject();
        int f0 = fr_cnt;
        int bad_col [4] = '{4, 0, 0, 96};
        int bad_len [4] = '{3, 5, 0, 3};
        for (int i = 0; i < 4; i++) begin
            issue(bad_col[i], bad_len[i], 1'b0);
            repeat (10) @(negedge clk);
            chk(!busy && drv_sel_n == 4'hF, "R2", "rejected command", {busy, drv_sel_n}, 5'h0F);
        end
        chk(fr_cnt == f0, "R2", "frames after rejects", fr_cnt, f0);
    endtask

    task automatic t_first_write();
        int f0 = fr_cnt, s0 = src_idx;
        issue(0, 3, 1'b0);
        chk(busy, "R10", "busy after accept", busy, 1);
        wait_idle();
        chk(fr_cnt == f0 + 2, "R3", "frame count with priming", fr_cnt - f0, 2);
        chk(fr_cs[f0] == 4'hF && fr_bits[f0] == '0, "R3", "priming frame", fr_bits[f0], 0);
        expect_frame(f0 + 1, 4'b1110, 0, 1'b0, wr_data(s0), "R4");
        chk(src_idx == s0 + 3, "R8", "bytes taken", src_idx - s0, 3);
        chk(drv_sel_n == 4'hF && !busy, "R10", "released at end", drv_sel_n, 4'hF);
    endtask

    task automatic t_span();
        int f0 = fr_cnt, s0 = src_idx;
        issue(21, 9, 1'b0);
        wait_idle();
        chk(fr_cnt == f0 + 3, "R3", "no second priming frame", fr_cnt - f0, 3);
        expect_frame(f0,     4'b1110, 21, 1'b0, wr_data(s0),     "R6");
        expect_frame(f0 + 1, 4'b1101, 0,  1'b0, wr_data(s0 + 3), "R6");
        expect_frame(f0 + 2, 4'b1101, 3,  1'b0, wr_data(s0 + 6), "R6");
        chk(src_idx == s0 + 9, "R8", "bytes taken across boundary", src_idx - s0, 9);
    endtask

    task automatic t_chip2();
        int f0 = fr_cnt, s0 = src_idx;
        issue(51, 3, 1'b0);
        wait_idle();
        expect_frame(f0, 4'b1011, 3, 1'b0, wr_data(s0), "R5");
    endtask

    task automatic t_wrap();
        int f0 = fr_cnt, s0 = src_idx;
        issue(93, 6, 1'b0);
        wait_idle();
        expect_frame(f0,     4'b0111, 21, 1'b0, wr_data(s0),     "R5");
        expect_frame(f0 + 1, 4'b1110, 0,  1'b0, wr_data(s0 + 3), "R6");
    endtask

    task automatic t_read();
        int f0 = fr_cnt, s0 = src_idx, r0 = rd_cnt;
        rd_pat = 24'hC35A96;
        issue(30, 3, 1'b1);
        wait_idle();
        expect_frame(f0, 4'b1101, 6, 1'b1, 24'h0, "R11");
        chk(rd_cnt == r0 + 3, "R9", "read bytes", rd_cnt - r0, 3);
        chk(rd_got[r0] == 8'h96 && rd_got[r0+1] == 8'h5A && rd_got[r0+2] == 8'hC3, "R9",
            "read data", {rd_got[r0+2], rd_got[r0+1], rd_got[r0]}, 24'hC35A96);
        chk(src_idx == s0, "R11", "no bytes taken in read", src_idx - s0, 0);
    endtask

    task automatic t_busy_ignore();
        int f0 = fr_cnt, s0 = src_idx, r0 = rd_cnt;
        issue(0, 6, 1'b0);
        repeat (20) @(negedge clk);
        issue(48, 3, 1'b1);
        wait_idle();
        chk(fr_cnt == f0 + 2, "R10", "frames with ignored command", fr_cnt - f0, 2);
        expect_frame(f0,     4'b1110, 0, 1'b0, wr_data(s0),     "R10");
        expect_frame(f0 + 1, 4'b1110, 3, 1'b0, wr_data(s0 + 3), "R10");
        chk(rd_cnt == r0, "R11", "no read-valid in write", rd_cnt - r0, 0);
    endtask

    task automatic t_timing();
        chk(hi_min == HALF && hi_max == HALF, "R7", "high phase length", {hi_min, hi_max}, {HALF, HALF});
        chk(gap_min >= HALF, "R7", "gap between frames", gap_min, HALF);
        chk(glitch == 0, "R4", "data change while clock high", glitch, 0);
    endtask

    initial begin
        bit wd = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        fork
            begin
                t_reset();
                t_reject();
                t_first_write();
                t_span();
                t_chip2();
                t_wrap();
                t_read();
                t_busy_ignore();
                t_timing();
            end
            begin
                repeat (100000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) chk(1'b0, "R10", "watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule